// File: doc/BRIEF.md
# DS2 Four-Tributary Bit-Interleaved Multiplexer

This block combines four DS1 tributary bit streams into one serial DS2 stream. Each tributary writes its bits into a private bit FIFO, one bit per `trib_vld` strobe. The block reads the FIFOs in strict rotation to fill the payload of a 1176-bit M-frame. It inserts the multiframe (M), framing (F) and stuff-control (C) overhead bits itself. Rate differences between the tributaries and the DS2 clock are absorbed by pulse stuffing. Once per subframe, one tributary's FIFO level is compared with a programmable threshold. When the level is short, that tributary's reserved slot carries a dummy bit and nothing is read from its FIFO. The decision is announced to the far end by three identical C bits.

The frame is 4 subframes of 6 blocks of 49 bits. Bit 0 of each block is overhead and bits 1..48 are payload. The block emits one line bit per clock from a register. `ds2_frame_start` is high during the cycle that carries frame bit 0. A tributary bit that arrives while its FIFO already holds `FIFO_DEPTH` bits is discarded.

Top module: `ds2_mux`

## Requirements
- R1: Output positions cycle through 1176 bits per frame. `ds2_frame_start` is 1 exactly when the output bit is frame position 0, one bit per clock.
- R2: In every block, payload offset k (1..48, counted after the overhead bit) carries the next bit, in arrival order, of tributary (k-1) mod 4.
- R3: The overhead bit of block 1 of subframes 0, 1 and 2 is 0, 1 and 1. In subframe 3 it equals `x_bit_cfg` as sampled at the clock edge that loads that bit.
- R4: The overhead bit of block 3 is 0 and that of block 6 is 1 in every subframe.
- R5: The overhead bits of blocks 2, 4 and 5 of subframe i all equal the stuff decision for tributary i in that subframe (1 = stuff, 0 = data).
- R6: The stuff decision for subframe i is 1 when the fill level of FIFO i is below `stuff_thresh`. The level is sampled at the clock edge that loads the subframe's first bit, and the decision holds for the whole subframe.
- R7: The stuff slot of subframe i is payload offset i+1 of block 6. When the decision is 1, the slot carries 0 and no bit is read from FIFO i. When the decision is 0, the slot carries tributary data as in R2.
- R8: A payload read from an empty FIFO outputs 0. `underflow_err` then sets and stays 1 until reset, provided that tributary has received at least one bit since reset. Reads from a never-written FIFO output 0 without setting the flag.
- R9: While reset is asserted, `ds2_bit`, `ds2_frame_start` and `underflow_err` are 0 and the FIFOs are emptied. The first clock after release outputs frame position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, one DS2 bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| trib_bit | input | NUM_TRIB | Data bit of each tributary |
| trib_vld | input | NUM_TRIB | Write strobe for each tributary FIFO |
| stuff_thresh | input | $clog2(FIFO_DEPTH)+1 | Fill level below which a stuff is requested |
| x_bit_cfg | input | 1 | Value carried by the fourth M bit |
| ds2_bit | output | 1 | Serial DS2 line bit |
| ds2_frame_start | output | 1 | High while frame position 0 is on the line |
| underflow_err | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with its defaults: 49-bit blocks, 6 blocks per subframe, 4 subframes and tributaries, and 16-deep FIFOs. This gives a 5-bit threshold that can sit above any reachable level (31, so every tributary stuffs in every subframe) or at 0 (no stuffing at all). Each tributary is fed by a closed loop with its own target level. At a threshold of 8, some tributaries therefore stuff every time, some never stuff, and one toggles between the two. Starving one tributary and then feeding it again, followed by a second reset, reaches the underflow flag, its stickiness and its clearing.

// File: rtl/ds2_mux_pkg.sv
package ds2_mux_pkg;

   // kinds of overhead bit, indexed by block within a subframe
   typedef enum logic [1:0] {
      OH_MFRM = 2'd0,
      OH_FLO  = 2'd1,
      OH_FHI  = 2'd2,
      OH_CTL  = 2'd3
   } oh_kind_e;

   localparam int STD_BLK_LEN     = 49;
   localparam int STD_BLK_PER_SUB = 6;
   localparam int STD_NUM_SUB     = 4;

   // fixed overhead layout of a six-block subframe
   function automatic oh_kind_e oh_kind_of(input int blk);
      case (blk)
         0:       return OH_MFRM;
         2:       return OH_FLO;
         5:       return OH_FHI;
         default: return OH_CTL;
      endcase
   endfunction

endpackage

// File: rtl/ds2_trib_fifo.sv
module ds2_trib_fifo #(
   parameter  int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          din,
   input  logic          pop,
   output logic          dout,
   output logic          empty,
   output logic [LW-1:0] level
);

   generate
      if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("ds2_trib_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] mem;
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [LW-1:0]    count;
   logic             rd_ok, wr_ok;

   assign empty = (count == '0);
   assign rd_ok = pop && !empty;
   assign wr_ok = push && ((count != LW'(DEPTH)) || rd_ok);
   assign dout  = mem[rd_ptr];
   assign level = count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
         if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
         count <= count + LW'(wr_ok) - LW'(rd_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= din;
   end

endmodule

// File: rtl/ds2_frame_timer.sv
module ds2_frame_timer #(
   parameter  int BLK_LEN     = 49,
   parameter  int BLK_PER_SUB = 6,
   parameter  int NUM_SUB     = 4,
   localparam int IW          = $clog2(BLK_LEN),
   localparam int BW          = $clog2(BLK_PER_SUB),
   localparam int SW          = $clog2(NUM_SUB)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [IW-1:0] bit_idx,
   output logic [BW-1:0] blk_idx,
   output logic [SW-1:0] sub_idx,
   output logic          frame_first
);

   logic blk_end, sub_end;

   assign blk_end     = (bit_idx == IW'(BLK_LEN - 1));
   assign sub_end     = blk_end && (blk_idx == BW'(BLK_PER_SUB - 1));
   assign frame_first = (bit_idx == '0) && (blk_idx == '0) && (sub_idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= '0;
         blk_idx <= '0;
         sub_idx <= '0;
      end else begin
         bit_idx <= blk_end ? '0 : bit_idx + IW'(1);
         if (blk_end) blk_idx <= sub_end ? '0 : blk_idx + BW'(1);
         if (sub_end) sub_idx <= (sub_idx == SW'(NUM_SUB - 1)) ? '0 : sub_idx + SW'(1);
      end
   end

endmodule

// File: rtl/ds2_mux.sv
module ds2_mux
   import ds2_mux_pkg::*;
#(
   parameter  int   BLK_LEN     = STD_BLK_LEN,
   parameter  int   BLK_PER_SUB = STD_BLK_PER_SUB,
   parameter  int   NUM_SUB     = STD_NUM_SUB,
   parameter  int   NUM_TRIB    = 4,
   parameter  int   FIFO_DEPTH  = 16,
   parameter  logic STUFF_FILL  = 1'b0,
   localparam int   LVL_W       = $clog2(FIFO_DEPTH) + 1,
   localparam int   IW          = $clog2(BLK_LEN),
   localparam int   BW          = $clog2(BLK_PER_SUB),
   localparam int   SW          = $clog2(NUM_SUB),
   localparam int   TW          = $clog2(NUM_TRIB)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TRIB-1:0] trib_bit,
   input  logic [NUM_TRIB-1:0] trib_vld,
   input  logic [LVL_W-1:0]    stuff_thresh,
   input  logic                x_bit_cfg,
   output logic                ds2_bit,
   output logic                ds2_frame_start,
   output logic                underflow_err
);

   // elaboration-time checks of the frame geometry
   generate
      if (NUM_SUB != NUM_TRIB) begin : g_bad_sub
         $error("ds2_mux: one subframe per tributary is required");
      end
      if ((1 << TW) != NUM_TRIB) begin : g_bad_trib
         $error("ds2_mux: NUM_TRIB must be a power of two");
      end
      if ((BLK_LEN - 1) % NUM_TRIB != 0) begin : g_bad_blk
         $error("ds2_mux: payload per block must divide evenly among tributaries");
      end
      if (BLK_PER_SUB != 6) begin : g_bad_layout
         $error("ds2_mux: overhead layout assumes six blocks per subframe");
      end
   endgenerate

   logic [IW-1:0]       bit_idx, pay_idx;
   logic [BW-1:0]       blk_idx;
   logic [SW-1:0]       sub_idx;
   logic                frame_first;
   logic [NUM_TRIB-1:0] pop, empty, dout, armed_q;
   logic [LVL_W-1:0]    lvl [NUM_TRIB];
   logic [TW-1:0]       trib_sel;
   logic                sub_start, is_pay, is_slot, stuffing, hole;
   logic                dec_q, m_val, ovh_val, nxt_bit;

   ds2_frame_timer #(
      .BLK_LEN    (BLK_LEN),
      .BLK_PER_SUB(BLK_PER_SUB),
      .NUM_SUB    (NUM_SUB)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_idx    (bit_idx),
      .blk_idx    (blk_idx),
      .sub_idx    (sub_idx),
      .frame_first(frame_first)
   );

   generate
      for (genvar g = 0; g < NUM_TRIB; g++) begin : g_trib
         ds2_trib_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk  (clk),
            .rst_n(rst_n),
            .push (trib_vld[g]),
            .din  (trib_bit[g]),
            .pop  (pop[g]),
            .dout (dout[g]),
            .empty(empty[g]),
            .level(lvl[g])
         );
      end
   endgenerate

   // position decode
   assign sub_start = (bit_idx == '0) && (blk_idx == '0);
   assign is_pay    = (bit_idx != '0);
   assign pay_idx   = bit_idx - IW'(1);
   assign trib_sel  = pay_idx[TW-1:0];
   assign is_slot   = (blk_idx == BW'(BLK_PER_SUB - 1)) && (pay_idx == IW'(sub_idx));
   assign stuffing  = is_slot && dec_q;
   assign hole      = is_pay && !stuffing && empty[trib_sel];

   always_comb begin
      pop = '0;
      if (is_pay && !stuffing) pop[trib_sel] = 1'b1;
   end

   // overhead bit for the current block
   assign m_val = (sub_idx == SW'(NUM_SUB - 1)) ? x_bit_cfg : (sub_idx != '0);

   always_comb begin
      case (oh_kind_of(int'(blk_idx)))
         OH_MFRM: ovh_val = m_val;
         OH_FLO:  ovh_val = 1'b0;
         OH_FHI:  ovh_val = 1'b1;
         default: ovh_val = dec_q;
      endcase
   end

   always_comb begin
      if (!is_pay)       nxt_bit = ovh_val;
      else if (stuffing) nxt_bit = STUFF_FILL;
      else if (hole)     nxt_bit = 1'b0;
      else               nxt_bit = dout[trib_sel];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_q           <= 1'b0;
         armed_q         <= '0;
         ds2_bit         <= 1'b0;
         ds2_frame_start <= 1'b0;
         underflow_err   <= 1'b0;
      end else begin
         if (sub_start) dec_q <= (lvl[sub_idx] < stuff_thresh);
         armed_q         <= armed_q | trib_vld;
         ds2_bit         <= nxt_bit;
         ds2_frame_start <= frame_first;
         underflow_err   <= underflow_err | (hole & armed_q[trib_sel]);
      end
   end

endmodule

// File: rtl/ds2_mux_chk.sv
module ds2_mux_chk #(
   parameter  int BLK_LEN     = 49,
   parameter  int BLK_PER_SUB = 6,
   parameter  int NUM_SUB     = 4,
   localparam int SUB_LEN     = BLK_LEN * BLK_PER_SUB,
   localparam int FRAME_LEN   = SUB_LEN * NUM_SUB,
   localparam int CW          = $clog2(FRAME_LEN)
) (
   input logic clk,
   input logic rst_n,
   input logic ds2_bit,
   input logic ds2_frame_start,
   input logic underflow_err,
   input logic x_bit_cfg
);

   logic [CW-1:0] cnt;
   logic          seen, c_ref;
   int            pos, in_sub;

   always_comb begin
      pos    = (int'(cnt) == FRAME_LEN - 1) ? 0 : int'(cnt) + 1;
      in_sub = pos % SUB_LEN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         seen  <= 1'b0;
         c_ref <= 1'b0;
      end else begin
         cnt  <= ds2_frame_start ? '0 : cnt + CW'(1);
         seen <= seen | ds2_frame_start;
         if (seen && in_sub == BLK_LEN) c_ref <= ds2_bit;
      end
   end

   // R1
   frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (ds2_frame_start == (int'(cnt) == FRAME_LEN - 1)));

   // R3
   m_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && in_sub == 0 && pos < 3 * SUB_LEN) |-> (ds2_bit == (pos != 0)));

   // R3
   m_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && pos == 3 * SUB_LEN) |-> (ds2_bit == $past(x_bit_cfg)));

   // R4
   f_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && in_sub == 2 * BLK_LEN) |-> !ds2_bit);

   // R4
   f_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && in_sub == 5 * BLK_LEN) |-> ds2_bit);

   // R5
   c_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && (in_sub == 3 * BLK_LEN || in_sub == 4 * BLK_LEN)) |-> (ds2_bit == c_ref));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_err |=> underflow_err);

endmodule

bind ds2_mux ds2_mux_chk #(
   .BLK_LEN    (BLK_LEN),
   .BLK_PER_SUB(BLK_PER_SUB),
   .NUM_SUB    (NUM_SUB)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ds2_bit        (ds2_bit),
   .ds2_frame_start(ds2_frame_start),
   .underflow_err  (underflow_err),
   .x_bit_cfg      (x_bit_cfg)
);

// File: tb/ds2_mux_test.sv
module ds2_mux_test;

   localparam int NT    = 4;
   localparam int DEPTH = 16;
   localparam int FRAME = 1176;
   localparam int SUBL  = 294;
   localparam int BLKL  = 49;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NT-1:0] trib_bit = '0;
   logic [NT-1:0] trib_vld = '0;
   logic [4:0]    stuff_thresh = 5'd8;
   logic          x_bit_cfg = 1'b1;
   logic          ds2_bit, ds2_frame_start, underflow_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   ds2_mux uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .trib_bit       (trib_bit),
      .trib_vld       (trib_vld),
      .stuff_thresh   (stuff_thresh),
      .x_bit_cfg      (x_bit_cfg),
      .ds2_bit        (ds2_bit),
      .ds2_frame_start(ds2_frame_start),
      .underflow_err  (underflow_err)
   );

   always #4 clk = ~clk;

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit    fq [NT][$];
   bit    m_armed [NT];
   int    pos = 0;
   bit    m_dec = 1'b0;
   logic  m_bit = 1'b0, m_fs = 1'b0, m_err = 1'b0;
   string m_tag = "R9";

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NT; i++) begin
            fq[i].delete();
            m_armed[i] = 1'b0;
         end
         pos = 0; m_dec = 1'b0;
         m_bit = 1'b0; m_fs = 1'b0; m_err = 1'b0;
         m_tag = "R9";
      end else begin
         int sub, r, blk, b, t;
         sub = pos / SUBL;
         r   = pos % SUBL;
         blk = r / BLKL;
         b   = r % BLKL;
         if (r == 0) m_dec = (fq[sub].size() < int'(stuff_thresh));
         if (b == 0) begin
            case (blk)
               0: begin m_bit = (sub == 3) ? x_bit_cfg : (sub != 0); m_tag = "R3"; end
               2: begin m_bit = 1'b0; m_tag = "R4"; end
               5: begin m_bit = 1'b1; m_tag = "R4"; end
               default: begin m_bit = m_dec; m_tag = "R5,R6"; end
            endcase
         end else begin
            t = (b - 1) % NT;
            if (blk == 5 && b - 1 == sub && m_dec) begin
               m_bit = 1'b0; m_tag = "R7";
            end else begin
               m_tag = (blk == 5 && b - 1 == sub) ? "R7" : "R2";
               if (fq[t].size() > 0) m_bit = fq[t].pop_front();
               else begin
                  m_bit = 1'b0;
                  if (m_armed[t]) m_err = 1'b1;
               end
            end
         end
         m_fs = (pos == 0);
         for (int i = 0; i < NT; i++) begin
            if (trib_vld[i]) begin
               fq[i].push_back(trib_bit[i]);
               m_armed[i] = 1'b1;
            end
         end
         pos = (pos + 1) % FRAME;
      end
   end

   // compare on every clock, between edges
   always @(posedge clk) begin
      #2;
      if (!done) begin
         chk(rst_n ? "R1" : "R9", "frame_start", ds2_frame_start, m_fs);
         chk(rst_n ? "R8" : "R9", "underflow_err", underflow_err, m_err);
         chk(m_tag, "ds2_bit", ds2_bit, m_bit);
      end
   end

   // closed-loop tributary sources
   int tgt [NT] = '{0, 0, 0, 0};
   int fill_cnt = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         trib_vld <= '0;
         fill_cnt <= 0;
      end else begin
         for (int i = 0; i < NT; i++) begin
            trib_bit[i] <= 1'($urandom);
            trib_vld[i] <= (fq[i].size() < tgt[i]) && (fq[i].size() < DEPTH - 1) &&
                           ((fill_cnt < 16) || ($urandom % 4 != 0));
         end
         if (fill_cnt < 16) fill_cnt <= fill_cnt + 1;
      end
   end

   task automatic run_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R9: state while reset is held
      repeat (3) @(negedge clk);
      chk("R9", "bit in reset", ds2_bit, 1'b0);
      chk("R9", "frame_start in reset", ds2_frame_start, 1'b0);
      chk("R9", "err in reset", underflow_err, 1'b0);
      tgt = '{6, 12, 8, 10};
      rst_n = 1'b1;
      // mixed stuffing at threshold 8 (R6, R7)
      run_cycles(6 * FRAME);
      chk("R8", "no underflow while fed", underflow_err, 1'b0);
      // every subframe stuffs, fourth M bit at 0 (R3, R6)
      stuff_thresh = 5'd31;
      x_bit_cfg = 1'b0;
      run_cycles(2 * FRAME);
      // no subframe stuffs
      stuff_thresh = 5'd0;
      x_bit_cfg = 1'b1;
      run_cycles(2 * FRAME);
      chk("R8", "no underflow before starvation", underflow_err, 1'b0);
      // starve tributary 3, then feed it again (R8)
      stuff_thresh = 5'd8;
      tgt[3] = 0;
      run_cycles(FRAME);
      chk("R8", "underflow flagged", underflow_err, 1'b1);
      tgt[3] = 10;
      run_cycles(FRAME);
      chk("R8", "underflow stays set", underflow_err, 1'b1);
      // second reset clears the flag (R9)
      rst_n = 1'b0;
      run_cycles(3);
      chk("R9", "err cleared by reset", underflow_err, 1'b0);
      rst_n = 1'b1;
      run_cycles(FRAME + 10);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule